// File: doc/BRIEF.md
# Branch Destination Trace Queue

This block keeps a short history of where the program went. Each taken branch presents its target address on a strobe. The block keeps the low 28 bits of that target in an eight-slot queue, and each slot carries a flag that marks it as holding a capture. On every capture the whole queue moves one slot toward the old end. The new target enters at slot 0, and whatever sat in slot 7 is lost.

A debugger empties the history through one read strobe. Each read returns a 32-bit word built from the oldest slot whose flag is set:

- Bit 31 holds the flag.
- Bits 30:28 read as zero.
- Bits 27:0 hold the stored target.

The read clears the flag of the slot it returned, so the next read returns the next capture in order. When no slot holds a capture, a read returns all zeros.

Captures are taken only while the trace-enable level is high. Turning tracing on wipes all flags, so a new trace session starts empty. A synchronous, active-high power-on reset clears the flags. It leaves the stored address bits untouched.

Top module: `brtrace_queue`

## Requirements
- R1: After reset, `rd_data` is 0x0000_0000 and no slot is flagged, so a read returns 0x0000_0000.
- R2: A `br_valid` cycle with `trace_en` high stores `br_addr[27:0]` in slot 0 with its flag set. A later read returns bit 31 = 1 and bits 27:0 = that address.
- R3: Bits 30:28 of `rd_data` are always 0.
- R4: Successive reads return the captured targets oldest first, in the order they were captured.
- R5: A read clears the flag of the slot it returned, so that capture is never returned a second time.
- R6: A read while no slot is flagged updates `rd_data` to 0x0000_0000 and changes no flag.
- R7: When all eight slots are flagged, a new capture discards the oldest capture. After ten captures, eight reads return captures three to ten.
- R8: A `br_valid` cycle with `trace_en` low stores nothing. The captures already held are read back unchanged.
- R9: A clock edge at which `trace_en` is high and was low at the previous edge clears every flag.
- R10: When a capture and a read fall on the same edge, the capture is taken. The read returns the oldest flagged slot as it stood before the shift, and that capture is not returned again.
- R11: `rd_data` changes only at an edge where `rd_en` is high. Otherwise it holds its value, even across captures.
- R12: Bits 31:28 of `br_addr` are not stored and never appear in `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| trace_en | input | 1 | Trace enable level; a rising level clears all flags |
| br_valid | input | 1 | Strobe: a taken branch this cycle |
| br_addr | input | 32 | Branch target address |
| rd_en | input | 1 | Strobe: read and consume the oldest capture |
| rd_data | output | 32 | Registered read word: {flag, 3'b000, target[27:0]} |

## Verification
A capture and a read can fall on the same edge. The two then compete: one shifts the queue, and the other picks and clears a slot. The bench provokes this by raising `br_valid` and `rd_en` together, both with a partly filled queue and with all eight slots full. In the full case the slot being read is the one the shift pushes out. The reference model pops the expected word before it appends the new target. The following reads must then walk the remaining captures plus the new one, with no repeat and no gap.

// File: rtl/brq_pkg.sv
package brq_pkg;

    localparam int TQ_WORD_W = 32;
    localparam int TQ_KEEP_W = 28;
    localparam int TQ_PAD_W  = TQ_WORD_W - 1 - TQ_KEEP_W;

    typedef struct packed {
        logic                 vld;
        logic [TQ_KEEP_W-1:0] tgt;
    } tq_ent_t;

    function automatic logic [TQ_WORD_W-1:0] tq_word(input tq_ent_t e);
        logic [TQ_WORD_W-1:0] w;
        if (e.vld) begin
            w = {1'b1, {TQ_PAD_W{1'b0}}, e.tgt};
        end else begin
            w = '0;
        end
        return w;
    endfunction

endpackage

// File: rtl/brq_en_ctl.sv
module brq_en_ctl (
    input  logic clk,
    input  logic rst,
    input  logic trace_en,
    input  logic br_valid,
    output logic cap,
    output logic clr_all
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= trace_en;
        end
    end

    assign cap     = br_valid & trace_en;
    assign clr_all = trace_en & ~en_q;

    // R9: a wipe is a single-edge event per rise of the enable
    p_wipe_single_r9: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> !clr_all);

endmodule

// File: rtl/brq_store.sv
module brq_store
    import brq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap,
    input  logic [TQ_KEEP_W-1:0] new_tgt,
    input  logic                 clr_all,
    input  logic                 rd_clr,
    input  logic [IDX_W-1:0]     rd_idx,
    output tq_ent_t [DEPTH-1:0]  ents
);
    logic [DEPTH-1:0] vld_vec;
    logic [TQ_KEEP_W-1:0] tgt_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic                 v_r;
        logic [TQ_KEEP_W-1:0] t_r;
        logic                 hit_here;

        assign hit_here = rd_clr && (rd_idx == IDX_W'(g));

        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_r <= 1'b0;
                end else if (cap) begin
                    v_r <= 1'b1;
                end else begin
                    v_r <= v_r & ~clr_all & ~hit_here;
                end
            end

            always_ff @(posedge clk) begin
                if (cap) begin
                    t_r <= new_tgt;
                end
            end
        end else begin : g_body
            logic hit_prev;
            assign hit_prev = rd_clr && (rd_idx == IDX_W'(g - 1));

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_r <= 1'b0;
                end else if (cap) begin
                    v_r <= vld_vec[g-1] & ~clr_all & ~hit_prev;
                end else begin
                    v_r <= v_r & ~clr_all & ~hit_here;
                end
            end

            always_ff @(posedge clk) begin
                if (cap) begin
                    t_r <= tgt_arr[g-1];
                end
            end
        end

        assign vld_vec[g]  = v_r;
        assign tgt_arr[g]  = t_r;
        assign ents[g].vld = v_r;
        assign ents[g].tgt = t_r;
    end

    // R2: a capture always lands flagged at the entry slot
    p_cap_head_r2: assert property (@(posedge clk) disable iff (rst)
        cap |=> vld_vec[0]);

    // R8: with no capture, wipe or read, no flag moves
    p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!cap && !clr_all && !rd_clr) |=> $stable(vld_vec));

    // R9: a wipe without a capture leaves nothing flagged
    p_wipe_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !cap) |=> (vld_vec == '0));

    // R5: a read without capture drops exactly one flag
    p_read_drops_one_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !cap && !clr_all) |=>
            ($countones(vld_vec) + 1 == $countones($past(vld_vec))));

endmodule

// File: rtl/brq_pick.sv
module brq_pick
    import brq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  tq_ent_t [DEPTH-1:0]  ents,
    output logic                 any_vld,
    output logic [IDX_W-1:0]     idx,
    output logic [TQ_WORD_W-1:0] word
);
    always_comb begin
        any_vld = 1'b0;
        idx     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ents[i].vld) begin
                any_vld = 1'b1;
                idx     = IDX_W'(i);
            end
        end
    end

    assign word = any_vld ? tq_word(ents[idx]) : '0;

endmodule

// File: rtl/brtrace_queue.sv
module brtrace_queue
    import brq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trace_en,
    input  logic                 br_valid,
    input  logic [ADDR_W-1:0]    br_addr,
    input  logic                 rd_en,
    output logic [TQ_WORD_W-1:0] rd_data
);
    logic                 cap;
    logic                 clr_all;
    logic                 any_vld;
    logic                 rd_clr;
    logic [IDX_W-1:0]     rd_idx;
    logic [TQ_WORD_W-1:0] pick_word;
    logic [TQ_WORD_W-1:0] rd_data_q;
    tq_ent_t [DEPTH-1:0]  ents;
    logic                 unused_hi_bits;

    assign unused_hi_bits = ^br_addr[ADDR_W-1:TQ_KEEP_W];

    brq_en_ctl u_en (
        .clk      (clk),
        .rst      (rst),
        .trace_en (trace_en),
        .br_valid (br_valid),
        .cap      (cap),
        .clr_all  (clr_all)
    );

    brq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .new_tgt (br_addr[TQ_KEEP_W-1:0]),
        .clr_all (clr_all),
        .rd_clr  (rd_clr),
        .rd_idx  (rd_idx),
        .ents    (ents)
    );

    brq_pick #(.DEPTH(DEPTH)) u_pick (
        .ents    (ents),
        .any_vld (any_vld),
        .idx     (rd_idx),
        .word    (pick_word)
    );

    assign rd_clr = rd_en & any_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else if (rd_en) begin
            rd_data_q <= pick_word;
        end
    end

    assign rd_data = rd_data_q;

    // R3: reserved bits of the read word never set
    p_rsv_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rd_data[TQ_WORD_W-2:TQ_KEEP_W] == '0);

    // R11: the read word moves only on a read
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R6: a read of an empty queue yields zero
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !any_vld) |=> (rd_data == '0));

endmodule

// File: tb/brtrace_queue_tb.sv
`timescale 1ns/1ps
module brtrace_queue_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_en = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_addr = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;

    logic [27:0] mdl[$];
    bit          en_m = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_exp = '0;
    logic        rd_seen = 1'b0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    brtrace_queue u_dut (
        .clk      (clk),
        .rst      (rst),
        .trace_en (trace_en),
        .br_valid (br_valid),
        .br_addr  (br_addr),
        .rd_en    (rd_en),
        .rd_data  (rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        if (mdl.size() == 0) return 32'h0;
        return {1'b1, 3'b000, mdl[0]};
    endfunction

    // driver: one cycle of stimulus, expected read words go to the scoreboard
    task automatic op(input bit br, input logic [31:0] a, input bit rd, input string tag);
        br_valid = br;
        br_addr  = a;
        rd_en    = rd;
        if (rd) begin
            last_exp = model_word();
            exp_q.push_back(last_exp);
            tag_q.push_back(tag);
            if (mdl.size() > 0) void'(mdl.pop_front());
        end
        if (br && en_m) begin
            mdl.push_back(a[27:0]);
            if (mdl.size() > 8) void'(mdl.pop_front());
        end
        @(negedge clk);
        br_valid = 1'b0;
        rd_en    = 1'b0;
    endtask

    task automatic set_en(input bit v);
        trace_en = v;
        if (v && !en_m) mdl.delete();
        en_m = v;
        @(negedge clk);
    endtask

    // monitor: compare every read result one edge after its strobe
    always @(posedge clk) rd_seen <= rd_en && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("monitor underflow", rd_data, 32'hxxxx_xxxx);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset rd_data", rd_data, 32'h0);
        op(0, 0, 1, "R1 read after reset");
        op(0, 0, 1, "R6 empty read");

        set_en(1);
        op(1, 32'h0123_4567, 0, "");
        op(0, 0, 1, "R2 single capture");
        op(0, 0, 1, "R5 flag cleared by read");

        for (int i = 0; i < 3; i++) op(1, 32'h0A00_0010 + i * 32'h111, 0, "");
        for (int i = 0; i < 3; i++) op(0, 0, 1, "R4 capture order");
        op(0, 0, 1, "R6 drained read");

        for (int i = 0; i < 10; i++) op(1, 32'h0B00_0000 + i * 32'h2_0203, 0, "");
        for (int i = 0; i < 8; i++) op(0, 0, 1, "R7 oldest discarded");
        op(0, 0, 1, "R7 only eight kept");

        op(1, 32'h0C00_0001, 0, "");
        op(1, 32'h0C00_0002, 0, "");
        op(1, 32'h0C00_0003, 1, "R10 read with capture");
        for (int i = 0; i < 3; i++) op(0, 0, 1, "R10 walk after overlap");

        for (int i = 0; i < 8; i++) op(1, 32'h0D00_0100 + i, 0, "");
        op(1, 32'h0D00_0200, 1, "R10 full queue overlap");
        for (int i = 0; i < 8; i++) op(0, 0, 1, "R10 full walk");
        op(0, 0, 1, "R10 drained");

        op(1, 32'hF234_5678, 0, "");
        op(0, 0, 1, "R12 high bits dropped");
        chk("R12 value", rd_data, 32'h8234_5678);

        op(1, 32'h0E00_0001, 0, "");
        op(1, 32'h0E00_0002, 0, "");
        set_en(0);
        op(1, 32'h0E00_0099, 0, "");
        op(0, 0, 1, "R8 disabled capture ignored");
        op(0, 0, 1, "R8 disabled capture ignored");
        op(0, 0, 1, "R8 nothing extra");

        set_en(1);
        op(1, 32'h0F00_0001, 0, "");
        op(1, 32'h0F00_0002, 0, "");
        set_en(0);
        set_en(1);
        op(0, 0, 1, "R9 rise wipes flags");
        op(1, 32'h0F00_0003, 0, "");
        op(0, 0, 1, "R9 capture after wipe");

        op(1, 32'h0A5A_5A5A, 0, "");
        op(0, 0, 1, "R11 read word");
        repeat (4) @(negedge clk);
        chk("R11 hold while idle", rd_data, last_exp);
        op(1, 32'h0123_0000, 0, "");
        chk("R11 hold across capture", rd_data, last_exp);
        chk("R3 reserved bits", {29'h0, rd_data[30:28]}, 32'h0);

        @(negedge clk);
        @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule